// File: doc/BRIEF.md
# Mode-Aware Freezing Watchdog Timer

This block is a watchdog down-counter. Software must keep refreshing it with a two-word service sequence. If it does not, the counter reaches zero and the block raises a reset request of fixed length. The counter watches the current power mode of the chip. In the deepest sleep mode it always stops counting. In the two lighter sleep modes it stops counting only when the matching configuration bit is set. When the freezing mode ends, counting goes on from the value the counter held; it does not reload.

When the counter is not frozen, it keeps counting in any sleep mode. An expiry there raises the reset request, so the watchdog can pull a hung system out of a sleep mode. While the block is disabled, the counter tracks the reload value and no reset request can appear.

Top module: `wdog_freeze`

## Requirements
- R1: While reset is active, `count` reads all ones and `wdReset` is low.
- R2: In run mode (`pwrMode` = 0) with the block enabled, `count` drops by one on each clock edge until it reaches zero.
- R3: In stop mode (`pwrMode` = 3) the counter holds its value and never expires, whatever the two freeze bits say.
- R4: In wait mode (`pwrMode` = 1) the counter freezes only if `freezeInWait` is set. In doze mode (`pwrMode` = 2) it freezes only if `freezeInDoze` is set. Each bit affects only its own mode.
- R5: When a freezing mode ends, counting resumes from the held value without a reload. A zero that was held while frozen expires on the first unfrozen edge.
- R6: A service write of 0x5555 followed by a service write of 0xAAAA loads `reloadVal` into the counter on the edge of the second write.
- R7: A write of any value other than 0x5555 or 0xAAAA, placed between the two keys, cancels the sequence. A lone 0xAAAA write has no effect on the count.
- R8: While `wdEnable` is low, `count` equals the `reloadVal` of the previous cycle and `wdReset` stays low.
- R9: If the counter is enabled, not frozen and at zero on a clock edge, `wdReset` goes high after that edge and stays high for exactly 4 clocks. This also applies in wait or doze mode when that mode is not frozen.
- R10: `count` stays at zero while `wdReset` is high. On the edge where `wdReset` falls, the counter loads `reloadVal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwrMode | input | 2 | Power mode: 0 run, 1 wait, 2 doze, 3 stop |
| reloadVal | input | CNT_W | Value loaded on service, on pulse end and while disabled |
| wdEnable | input | 1 | Enables counting and expiry |
| freezeInWait | input | 1 | Freeze the counter in wait mode |
| freezeInDoze | input | 1 | Freeze the counter in doze mode |
| svcWrite | input | 1 | Service write strobe |
| svcData | input | 16 | Service write data |
| wdReset | output | 1 | Reset request pulse |
| count | output | CNT_W | Current counter value |

## Verification
A wrong freeze decision shows up in `count` after the first clock edge in the affected mode: the counter either moves when it should hold or holds when it should move. A service tracker stuck in the armed state or the idle state shows up as a reload that appears or fails to appear on the edge of the 0xAAAA write. A fault in the pulse counter can make `wdReset` too short, too long, or never fall. It can also make the counter fail to reload. These faults show within the four clocks after an expiry.

// File: rtl/wdf_pkg.sv
package wdf_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_DOZE = 2'd2,
    MODE_STOP = 2'd3
  } pwrMode_e;

  // Commands from the control module to the counter datapath
  typedef struct packed {
    logic loadReload;
    logic decrement;
  } cntStrobe_t;
endpackage

// File: rtl/wdf_count.sv
module wdf_count #(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  wdf_pkg::cntStrobe_t strobe,
  input  logic [CNT_W-1:0]    reloadVal,
  output logic [CNT_W-1:0]    count,
  output logic                isZero
);
  localparam logic [CNT_W-1:0] RESET_VAL = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= RESET_VAL;
    end else if (strobe.loadReload) begin
      count <= reloadVal;
    end else if (strobe.decrement) begin
      count <= count - CNT_W'(1);
    end
  end

  assign isZero = (count == '0);
endmodule

// File: rtl/wdf_ctrl.sv
module wdf_ctrl #(
  parameter int          SVC_W     = 16,
  parameter int          PULSE_LEN = 4,
  parameter logic [15:0] KEY_FIRST = 16'h5555,
  parameter logic [15:0] KEY_LAST  = 16'hAAAA
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           pwrMode,
  input  logic                 wdEnable,
  input  logic                 freezeInWait,
  input  logic                 freezeInDoze,
  input  logic                 svcWrite,
  input  logic [SVC_W-1:0]     svcData,
  input  logic                 isZero,
  output wdf_pkg::cntStrobe_t  strobe,
  output logic                 wdReset
);
  import wdf_pkg::*;

  localparam int PULSE_W = $clog2(PULSE_LEN + 1);
  localparam logic [SVC_W-1:0] KEY_A = SVC_W'(KEY_FIRST);
  localparam logic [SVC_W-1:0] KEY_B = SVC_W'(KEY_LAST);

  pwrMode_e             modeNow;
  logic                 frozen;
  logic                 armed;
  logic                 svcDone;
  logic [PULSE_W-1:0]   pulseCnt;
  logic                 pulsing;
  logic                 pulseLast;
  logic                 expire;

  assign modeNow = pwrMode_e'(pwrMode);

  always_comb begin
    unique case (modeNow)
      MODE_STOP: frozen = 1'b1;
      MODE_WAIT: frozen = freezeInWait;
      MODE_DOZE: frozen = freezeInDoze;
      default:   frozen = 1'b0;
    endcase
  end

  // Two-key service sequence tracker
  assign svcDone = svcWrite && armed && (svcData == KEY_B);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (svcWrite) begin
      armed <= (svcData == KEY_A);
    end
  end

  // Reset pulse timer
  assign pulsing   = (pulseCnt != '0);
  assign pulseLast = (pulseCnt == PULSE_W'(1));
  assign expire    = wdEnable && !frozen && !pulsing && isZero && !svcDone;

  always_ff @(posedge clk) begin
    if (!rstN || !wdEnable) begin
      pulseCnt <= '0;
    end else if (expire) begin
      pulseCnt <= PULSE_W'(PULSE_LEN);
    end else if (pulsing) begin
      pulseCnt <= pulseCnt - PULSE_W'(1);
    end
  end

  assign wdReset = pulsing;

  always_comb begin
    strobe.loadReload = !wdEnable || svcDone || pulseLast;
    strobe.decrement  = wdEnable && !frozen && !pulsing && !isZero;
  end
endmodule

// File: rtl/wdog_freeze.sv
module wdog_freeze #(
  parameter int CNT_W     = 16,
  parameter int PULSE_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       pwrMode,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             wdEnable,
  input  logic             freezeInWait,
  input  logic             freezeInDoze,
  input  logic             svcWrite,
  input  logic [15:0]      svcData,
  output logic             wdReset,
  output logic [CNT_W-1:0] count
);
  wdf_pkg::cntStrobe_t strobe;
  logic                isZero;

  wdf_ctrl #(
    .SVC_W    (16),
    .PULSE_LEN(PULSE_LEN)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .pwrMode     (pwrMode),
    .wdEnable    (wdEnable),
    .freezeInWait(freezeInWait),
    .freezeInDoze(freezeInDoze),
    .svcWrite    (svcWrite),
    .svcData     (svcData),
    .isZero      (isZero),
    .strobe      (strobe),
    .wdReset     (wdReset)
  );

  wdf_count #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reloadVal(reloadVal),
    .count    (count),
    .isZero   (isZero)
  );
endmodule

// File: rtl/wdog_freeze_chk.sv
module wdog_freeze_chk #(
  parameter int CNT_W     = 16,
  parameter int PULSE_LEN = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       pwrMode,
  input logic [CNT_W-1:0] reloadVal,
  input logic             wdEnable,
  input logic             svcWrite,
  input logic             wdReset,
  input logic [CNT_W-1:0] count
);
  localparam int RUN_W = $clog2(PULSE_LEN + 2);
  logic [RUN_W-1:0] hiRun;

  always_ff @(posedge clk) begin
    if (!rstN || !wdReset) hiRun <= '0;
    else if (hiRun != RUN_W'(PULSE_LEN + 1)) hiRun <= hiRun + RUN_W'(1);
  end

  // R3: stop mode holds the count
  assert_stop_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wdEnable && pwrMode == 2'd3 && !svcWrite && !wdReset) |=> (count == $past(count)));

  // R2: run mode counts down by one
  assert_run_dec_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wdEnable && pwrMode == 2'd0 && !svcWrite && !wdReset && count != '0)
      |=> (count == CNT_W'($past(count) - CNT_W'(1))));

  // R8: disabled block tracks reload and stays quiet
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !wdEnable |=> (!wdReset && count == $past(reloadVal)));

  // R9: pulse never exceeds its fixed length
  assert_pulse_max_R9: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |-> (hiRun < RUN_W'(PULSE_LEN)));

  // R10: counter reloads when the pulse ends
  assert_pulse_end_reload_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdReset) |-> (count == $past(reloadVal)));

  // R10: count is held at zero during the pulse
  assert_pulse_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wdReset && $past(wdReset)) |-> (count == '0));
endmodule

bind wdog_freeze wdog_freeze_chk #(
  .CNT_W    (CNT_W),
  .PULSE_LEN(PULSE_LEN)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pwrMode  (pwrMode),
  .reloadVal(reloadVal),
  .wdEnable (wdEnable),
  .svcWrite (svcWrite),
  .wdReset  (wdReset),
  .count    (count)
);

// File: tb/wdog_freeze_tb.sv
`timescale 1ns/1ps
module wdog_freeze_tb;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN;
  logic [1:0]       pwrMode;
  logic [CNT_W-1:0] reloadVal;
  logic             wdEnable;
  logic             freezeInWait;
  logic             freezeInDoze;
  logic             svcWrite;
  logic [15:0]      svcData;
  logic             wdReset;
  logic [CNT_W-1:0] count;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdog_freeze #(.CNT_W(CNT_W), .PULSE_LEN(4)) u_dut (
    .clk(clk), .rstN(rstN), .pwrMode(pwrMode), .reloadVal(reloadVal),
    .wdEnable(wdEnable), .freezeInWait(freezeInWait), .freezeInDoze(freezeInDoze),
    .svcWrite(svcWrite), .svcData(svcData), .wdReset(wdReset), .count(count)
  );

  // vector: {mode[1:0], freezeWait, freezeDoze, cycles[7:0], expectFrozen}
  localparam int NVEC = 10;
  localparam logic [12:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 1'b0, 8'd5, 1'b0},
    {2'd1, 1'b0, 1'b0, 8'd3, 1'b0},
    {2'd1, 1'b1, 1'b0, 8'd4, 1'b1},
    {2'd2, 1'b0, 1'b0, 8'd2, 1'b0},
    {2'd2, 1'b0, 1'b1, 8'd6, 1'b1},
    {2'd3, 1'b0, 1'b0, 8'd7, 1'b1},
    {2'd3, 1'b1, 1'b1, 8'd3, 1'b1},
    {2'd1, 1'b0, 1'b1, 8'd3, 1'b0},
    {2'd2, 1'b1, 1'b0, 8'd2, 1'b0},
    {2'd0, 1'b1, 1'b1, 8'd4, 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic svc(input logic [15:0] d);
    svcWrite = 1'b1;
    svcData  = d;
    tick(1);
    svcWrite = 1'b0;
    svcData  = '0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 5000);
    checks++;
    failures++;
    $display("FAIL watchdog timeout actual=hung expected=finished");
    finishRun();
  end

  initial begin
    int expCnt;
    rstN = 1'b0; pwrMode = 2'd0; reloadVal = 16'd77; wdEnable = 1'b0;
    freezeInWait = 1'b0; freezeInDoze = 1'b0; svcWrite = 1'b0; svcData = '0;
    tick(3);
    chk("R1 count in reset", count, 32'hFFFF);
    chk("R1 wdReset in reset", wdReset, 0);

    rstN = 1'b1;
    tick(1);
    chk("R8 disabled tracks reload", count, 77);
    reloadVal = 16'd1000;
    tick(20);
    chk("R8 disabled count", count, 1000);
    chk("R8 disabled no reset", wdReset, 0);

    // table walk over power modes and freeze bits (R2 R3 R4 R5)
    wdEnable = 1'b1;
    expCnt = 1000;
    for (int i = 0; i < NVEC; i++) begin
      pwrMode      = VEC[i][12:11];
      freezeInWait = VEC[i][10];
      freezeInDoze = VEC[i][9];
      tick(int'(VEC[i][8:1]));
      if (!VEC[i][0]) expCnt = expCnt - int'(VEC[i][8:1]);
      chk($sformatf("R2 R3 R4 R5 vector %0d", i), count, expCnt);
    end
    pwrMode = 2'd0; freezeInWait = 1'b0; freezeInDoze = 1'b0;

    // R6: service reload
    svc(16'h5555); expCnt = expCnt - 1;
    chk("R6 first key decrements", count, expCnt);
    svc(16'hAAAA); expCnt = 1000;
    chk("R6 service reload", count, expCnt);
    tick(4); expCnt = expCnt - 4;
    chk("R2 count after service", count, expCnt);

    // R7: broken and incomplete sequences
    svc(16'h5555); svc(16'h1234); svc(16'hAAAA); expCnt = expCnt - 3;
    chk("R7 interrupted sequence", count, expCnt);
    svc(16'hAAAA); expCnt = expCnt - 1;
    chk("R7 lone second key", count, expCnt);

    // R9 R10: expiry in run mode
    wdEnable = 1'b0; reloadVal = 16'd5;
    tick(1);
    wdEnable = 1'b1;
    tick(5);
    chk("R9 count reached zero", count, 0);
    chk("R9 no pulse before expiry edge", wdReset, 0);
    tick(1);
    chk("R9 pulse rises", wdReset, 1);
    chk("R10 count held at zero", count, 0);
    tick(3);
    chk("R9 pulse still high at clock 4", wdReset, 1);
    tick(1);
    chk("R9 pulse fell after 4 clocks", wdReset, 0);
    chk("R10 reload after pulse", count, 5);

    // R9: expiry while in unfrozen wait mode
    pwrMode = 2'd1;
    tick(6);
    chk("R9 expiry in unfrozen wait", wdReset, 1);
    tick(4);
    chk("R10 reload after wait pulse", count, 5);

    // R3 R5: zero held in stop, expires on return to run
    pwrMode = 2'd0;
    tick(5);
    chk("R2 count at zero", count, 0);
    pwrMode = 2'd3;
    tick(10);
    chk("R3 stop blocks expiry", wdReset, 0);
    chk("R3 stop holds zero", count, 0);
    pwrMode = 2'd0;
    tick(1);
    chk("R5 expiry on resume", wdReset, 1);
    tick(4);
    chk("R10 reload after resume pulse", count, 5);

    finishRun();
  end
endmodule